// File: doc/BRIEF.md
# Interrupt Type Selector with Delayed Configuration Shadow

This block takes a single interrupt line from user logic and turns it into one of two kinds of request toward a link core. The first is a message signaled interrupt request, held until acknowledged. The second is a legacy INTx message request, either assert or deassert, also held until acknowledged. There is only one interrupt source, so no vector or source number is produced.

The choice between the two kinds follows a shadow copy of two configuration-space bits. The first is the MSI enable flag from the MSI message-control field; in configuration space it sits at bit 16 of the dword at offset 0x050. The second is the interrupt-disable flag of the command register at offset 0x004. A new pair of values is offered together with an update strobe. It reaches the shadow only after a fixed pipeline delay of `CFG_DELAY` cycles. An interrupt raised inside that window is therefore handled with the old setting, and it can go out as the wrong kind or be dropped. That outcome is deterministic and repeatable.

When MSI is off and the interrupt-disable flag is set, no legacy assert message is ever sent. The kind of a request is fixed at the moment it is launched, so a later configuration change does not alter a request that is already waiting.

Top module: `irq_type_sel`

## Requirements
- R1: After reset `msi_req` and `intx_req` are 0, and the effective mode is legacy (MSI off, INTx allowed).
- R2: In MSI mode a rising edge of `irq_src` sets `msi_req` one cycle after the edge is sampled. `msi_req` stays high until a cycle with `msi_ack` high, and it is 0 in the cycle that follows.
- R3: One MSI is requested per rising edge. A source held high produces no second request. A rising edge seen while `msi_req` is still pending is absorbed into that request.
- R4: In legacy mode (MSI off, disable flag clear) a rising edge sets `intx_req` with `intx_assert`=1 one cycle after the edge is sampled, held until `intx_ack`.
- R5: Once an assert has been acknowledged, a falling edge of `irq_src` requests a deassert message (`intx_req`=1, `intx_assert`=0) one cycle after the fall is sampled.
- R6: With MSI off and the disable flag set, a rising edge produces neither `msi_req` nor an INTx assert. The edge is lost: enabling legacy later while the source stays high raises nothing.
- R7: Configuration values sampled together with `cfg_upd` govern source edges sampled on the fourth clock edge after the strobe edge and later (`CFG_DELAY`=4). An edge sampled on the third clock edge after the strobe edge still uses the previous setting.
- R8: Changes on `cfg_msi_en` or `cfg_intx_dis` without `cfg_upd` have no effect on the type selected.
- R9: If INTx is asserted and the effective mode leaves legacy, a deassert message is requested even though the source is still high.
- R10: The kind of a request is latched at launch. A pending `msi_req` survives a later switch to legacy mode, and that edge never produces an INTx message.
- R11: While `intx_req` waits for `intx_ack`, `intx_req` stays high and `intx_assert` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 1 | Interrupt line from user logic |
| cfg_msi_en | input | 1 | MSI enable flag (config dword 0x050, bit 16) |
| cfg_intx_dis | input | 1 | Interrupt-disable flag of the command register (0x004) |
| cfg_upd | input | 1 | Strobe: capture the two config flags into the shadow pipeline |
| msi_ack | input | 1 | Acknowledge for `msi_req` |
| intx_ack | input | 1 | Acknowledge for `intx_req` |
| msi_req | output | 1 | MSI request, held until acknowledged |
| intx_req | output | 1 | Legacy INTx message request, held until acknowledged |
| intx_assert | output | 1 | Kind of INTx message: 1 = assert, 0 = deassert |

## Verification
Every request output is registered once after the edge detector, so a source edge driven before clock edge E shows on `msi_req` or `intx_req` just after E. The bench drives inputs and samples outputs on falling edges, and reads each result one half-cycle after the edge that should have produced it. A configuration strobe sampled at edge S takes effect at S+4. The bench therefore counts falling edges from the strobe and places source edges at S+3 and at S+4 to catch both sides of the window. Deassert requests follow the acknowledge of the assert by at least one cycle, and are checked after that acknowledge is given.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_MSI    = 2'd1,
    MODE_OFF    = 2'd2
  } irq_mode_e;

  typedef struct packed {
    logic msi_en;
    logic intx_dis;
  } cfg_bits_t;

  // MSI wins; legacy is silenced only when MSI is off and the disable flag is set.
  function automatic irq_mode_e decode_mode(cfg_bits_t c);
    if (c.msi_en)        return MODE_MSI;
    else if (c.intx_dis) return MODE_OFF;
    else                 return MODE_LEGACY;
  endfunction

endpackage

// File: rtl/cfg_shadow_pipe.sv
module cfg_shadow_pipe
  import irq_sel_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  cfg_bits_t cfg_in,
  output cfg_bits_t cfg_act
);
  localparam int STAGES = (DELAY < 2) ? 1 : DELAY - 1;

  logic      vld [STAGES];
  cfg_bits_t dat [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[i] <= 1'b0;
          dat[i] <= '0;
        end else begin
          vld[i] <= upd;
          dat[i] <= cfg_in;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[i] <= 1'b0;
          dat[i] <= '0;
        end else begin
          vld[i] <= vld[i-1];
          dat[i] <= dat[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg_act <= '0;
    else if (vld[STAGES-1])    cfg_act <= dat[STAGES-1];
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic rise,
  output logic fall
);
  logic src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign rise = src & ~src_q;
  assign fall = ~src & src_q;
endmodule

// File: rtl/msi_launch.sv
module msi_launch
  import irq_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  irq_mode_e mode,
  input  logic      ack,
  output logic      req,
  output logic      launch_ev
);
  assign launch_ev = rise && (mode == MODE_MSI) && !req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req <= 1'b0;
    else if (launch_ev) req <= 1'b1;
    else if (ack)       req <= 1'b0;
  end
endmodule

// File: rtl/intx_msg_fsm.sv
module intx_msg_fsm
  import irq_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src,
  input  logic      rise,
  input  irq_mode_e mode,
  input  logic      ack,
  output logic      req,
  output logic      kind_assert,
  output logic      asserted,
  output logic      assert_ev,
  output logic      deassert_ev
);
  logic legacy;
  logic pend_q;
  logic pend_n;

  assign legacy      = (mode == MODE_LEGACY);
  assign pend_n      = (pend_q | (rise & legacy)) & src & legacy;
  assign assert_ev   = !req && !asserted && pend_n;
  assign deassert_ev = !req && asserted && (!src || !legacy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req         <= 1'b0;
      kind_assert <= 1'b0;
      asserted    <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      pend_q <= pend_n & ~assert_ev;
      if (assert_ev) begin
        req         <= 1'b1;
        kind_assert <= 1'b1;
        asserted    <= 1'b1;
      end else if (deassert_ev) begin
        req         <= 1'b1;
        kind_assert <= 1'b0;
        asserted    <= 1'b0;
      end else if (req && ack) begin
        req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_type_sel.sv
module irq_type_sel
  import irq_sel_pkg::*;
#(
  parameter int CFG_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_src,
  input  logic cfg_msi_en,
  input  logic cfg_intx_dis,
  input  logic cfg_upd,
  input  logic msi_ack,
  input  logic intx_ack,
  output logic msi_req,
  output logic intx_req,
  output logic intx_assert
);
  cfg_bits_t cfg_in;
  cfg_bits_t cfg_act;
  irq_mode_e act_mode;
  logic      rise_ev;
  logic      fall_ev;
  logic      msi_launch_ev;
  logic      intx_assert_ev;
  logic      intx_deassert_ev;
  logic      intx_on;

  assign cfg_in   = '{msi_en: cfg_msi_en, intx_dis: cfg_intx_dis};
  assign act_mode = decode_mode(cfg_act);

  cfg_shadow_pipe #(.DELAY(CFG_DELAY)) u_shadow (
    .clk(clk), .rst_n(rst_n), .upd(cfg_upd), .cfg_in(cfg_in), .cfg_act(cfg_act)
  );

  irq_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .rise(rise_ev), .fall(fall_ev)
  );

  msi_launch u_msi (
    .clk(clk), .rst_n(rst_n), .rise(rise_ev), .mode(act_mode),
    .ack(msi_ack), .req(msi_req), .launch_ev(msi_launch_ev)
  );

  intx_msg_fsm u_intx (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .rise(rise_ev), .mode(act_mode),
    .ack(intx_ack), .req(intx_req), .kind_assert(intx_assert),
    .asserted(intx_on), .assert_ev(intx_assert_ev), .deassert_ev(intx_deassert_ev)
  );
endmodule

// File: rtl/irq_type_sel_chk.sv
module irq_type_sel_chk
  import irq_sel_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      irq_src,
  input logic      msi_ack,
  input logic      intx_ack,
  input logic      msi_req,
  input logic      intx_req,
  input logic      intx_assert,
  input irq_mode_e act_mode,
  input logic      rise_ev,
  input logic      msi_launch_ev,
  input logic      intx_assert_ev,
  input logic      intx_deassert_ev,
  input logic      intx_on
);
  AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req && !msi_ack |=> msi_req); // R2
  AST_MSI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req && msi_ack |=> !msi_req); // R2
  AST_MSI_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req) |-> $past(rise_ev)); // R3
  AST_INTX_ASSERT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    intx_assert_ev |-> irq_src); // R4
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    act_mode == MODE_OFF |-> !msi_launch_ev && !intx_assert_ev); // R6
  AST_LEAVE_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    intx_on && act_mode != MODE_LEGACY && !intx_req |-> intx_deassert_ev); // R9
  AST_SINGLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !(msi_launch_ev && intx_assert_ev)); // R10
  AST_INTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    intx_req && !intx_ack |=> intx_req && $stable(intx_assert)); // R11
endmodule

bind irq_type_sel irq_type_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .msi_ack(msi_ack),
  .intx_ack(intx_ack), .msi_req(msi_req), .intx_req(intx_req),
  .intx_assert(intx_assert), .act_mode(act_mode), .rise_ev(rise_ev),
  .msi_launch_ev(msi_launch_ev), .intx_assert_ev(intx_assert_ev),
  .intx_deassert_ev(intx_deassert_ev), .intx_on(intx_on)
);

// File: tb/irq_type_sel_tb_top.sv
module irq_type_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, irq_src, cfg_msi_en, cfg_intx_dis, cfg_upd, msi_ack, intx_ack;
  logic msi_req, intx_req, intx_assert;
  int   n_checks = 0;
  int   n_errors = 0;

  // {msi_en, intx_dis, expect msi_req, expect intx_req}
  localparam logic [3:0] VEC [4] = '{4'b1010, 4'b1110, 4'b0001, 4'b0100};

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_type_sel dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_msi_en(cfg_msi_en),
    .cfg_intx_dis(cfg_intx_dis), .cfg_upd(cfg_upd), .msi_ack(msi_ack),
    .intx_ack(intx_ack), .msi_req(msi_req), .intx_req(intx_req),
    .intx_assert(intx_assert)
  );

  task automatic chk(string req, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_src = 1'b0; cfg_msi_en = 1'b0; cfg_intx_dis = 1'b0;
    cfg_upd = 1'b0; msi_ack = 1'b0; intx_ack = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // Strobe is sampled on the next rising edge S; returns just after S.
  task automatic cfg_write(logic m, logic d);
    cfg_msi_en = m; cfg_intx_dis = d; cfg_upd = 1'b1;
    step(1);
    cfg_upd = 1'b0;
  endtask

  task automatic ack_intx();
    intx_ack = 1'b1; step(1); intx_ack = 1'b0;
  endtask

  task automatic ack_msi();
    msi_ack = 1'b1; step(1); msi_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 msi_req", msi_req, 1'b0);
    chk("R1 intx_req", intx_req, 1'b0);

    // Mode table walk: R2 R4 R6
    for (int i = 0; i < 4; i++) begin
      do_reset();
      cfg_write(VEC[i][3], VEC[i][2]);
      step(5);
      irq_src = 1'b1;
      step(1);
      chk("R2/R6 table msi_req", msi_req, VEC[i][1]);
      chk("R4/R6 table intx_req", intx_req, VEC[i][0]);
      if (VEC[i][0]) chk("R4 table intx_assert", intx_assert, 1'b1);
    end

    // R2 hold until ack, drop after ack; R3 no second request while high
    do_reset(); cfg_write(1'b1, 1'b0); step(5);
    irq_src = 1'b1; step(1);
    step(3);
    chk("R2 held without ack", msi_req, 1'b1);
    ack_msi();
    chk("R2 dropped after ack", msi_req, 1'b0);
    step(4);
    chk("R3 no repeat while high", msi_req, 1'b0);
    // R3 merge: new edge while pending is absorbed
    irq_src = 1'b0; step(1); irq_src = 1'b1; step(1);
    chk("R3 second edge request", msi_req, 1'b1);
    irq_src = 1'b0; step(1); irq_src = 1'b1; step(1);
    ack_msi();
    chk("R3 absorbed edge", msi_req, 1'b0);
    step(2);
    chk("R3 absorbed edge stays", msi_req, 1'b0);

    // R4 R5 R11 legacy assert/deassert
    do_reset();
    irq_src = 1'b1; step(1);
    chk("R4 assert req", intx_req, 1'b1);
    chk("R4 assert kind", intx_assert, 1'b1);
    step(3);
    chk("R11 held req", intx_req, 1'b1);
    chk("R11 held kind", intx_assert, 1'b1);
    ack_intx();
    chk("R4 cleared after ack", intx_req, 1'b0);
    irq_src = 1'b0; step(1);
    chk("R5 deassert req", intx_req, 1'b1);
    chk("R5 deassert kind", intx_assert, 1'b0);
    ack_intx();

    // R6 lost edge: disabled, then legacy enabled with source still high
    do_reset(); cfg_write(1'b0, 1'b1); step(5);
    irq_src = 1'b1; step(3);
    chk("R6 no intx when off", intx_req, 1'b0);
    cfg_write(1'b0, 1'b0); step(6);
    chk("R6 edge lost", intx_req, 1'b0);
    chk("R6 no msi", msi_req, 1'b0);

    // R7 window: edge at 3rd edge after strobe uses old mode
    do_reset(); cfg_write(1'b1, 1'b0); step(2);
    irq_src = 1'b1; step(1);
    chk("R7 old mode intx", intx_req, 1'b1);
    chk("R7 old mode no msi", msi_req, 1'b0);
    // R7 edge at 4th edge after strobe uses new mode
    do_reset(); cfg_write(1'b1, 1'b0); step(3);
    irq_src = 1'b1; step(1);
    chk("R7 new mode msi", msi_req, 1'b1);
    chk("R7 new mode no intx", intx_req, 1'b0);

    // R8 config without strobe is ignored
    do_reset();
    cfg_msi_en = 1'b1; cfg_intx_dis = 1'b1; step(6);
    irq_src = 1'b1; step(1);
    chk("R8 still legacy", intx_req, 1'b1);
    chk("R8 no msi", msi_req, 1'b0);

    // R9 leaving legacy while asserted forces deassert
    do_reset();
    irq_src = 1'b1; step(1);
    ack_intx();
    cfg_write(1'b1, 1'b0); step(4);
    chk("R9 deassert req", intx_req, 1'b1);
    chk("R9 deassert kind", intx_assert, 1'b0);
    chk("R9 no msi", msi_req, 1'b0);
    ack_intx();

    // R10 pending MSI survives switch to legacy, no INTx for it
    do_reset(); cfg_write(1'b1, 1'b0); step(5);
    irq_src = 1'b1; step(1);
    cfg_write(1'b0, 1'b0); step(6);
    chk("R10 msi kept", msi_req, 1'b1);
    chk("R10 no intx", intx_req, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule